// File: doc/BRIEF.md
# Parallel RGB Dot-Clock Timing Generator

This block drives a small colour panel over a parallel RGB interface with an 8-bit data bus. It counts dot clocks and lines to produce active-low horizontal and vertical sync, a data-enable strobe, and the byte stream for every visible pixel. With the default geometry the visible area is 320 pixels by 240 lines. A 24-bit colour pixel does not fit on the 8-bit bus, so each pixel takes three consecutive dot clocks and is sent as one byte of red, then one of green, then one of blue.

Pixels come from an external frame store in 16-bit 5-6-5 format. The block reads them in raster order through a simple read port. It widens each colour channel to 8 bits by copying its most significant bits into the vacant low bits. A single-cycle pulse marks the start of each vertical sync, so other logic can count frames or hold off buffer updates.

The default porch and pulse widths keep inside the panel's limits. Horizontally these are 8 clocks of sync, 24 of back porch and 4 of front porch. Vertically they are 1 line of sync, 3 of back porch and 1 of front porch. At a 24 MHz dot clock that gives close to 100 frames per second.

Top module: `rgb_dotclk_gen`

## Requirements
- R1: While reset is asserted and on the first two cycles after it, hsync_n and vsync_n are 1, de is 0, data is 0, vsync_edge is 0 and pix_rd is 0.
- R2: A line lasts H_SYNC + H_BACK + H_PIX*CPP + H_FRONT clocks, and hsync_n is 0 for the first H_SYNC clocks of every line, including blanking lines.
- R3: A frame lasts V_SYNC + V_BACK + V_LINES + V_FRONT lines, and vsync_n is 0 for the whole of the first V_SYNC lines, changing on the same clock as hsync_n.
- R4: de is 1 only on lines V_SYNC+V_BACK through V_SYNC+V_BACK+V_LINES-1. On those lines it is 1 for exactly H_PIX*CPP clocks, starting H_SYNC+H_BACK clocks after the line begins.
- R5: pix_rd pulses for one clock per visible pixel with pix_addr = line*H_PIX + column in raster order. The frame store returns the word on pix_data on the next clock. The first byte of that pixel appears on data two clocks after the pulse.
- R6: Within a pixel the bus carries red on the first of its CPP clocks, green on the second and blue on the third.
- R7: Colour bytes are widened from the 5-6-5 word by bit replication: red = {p[15:11], p[15:13]}, green = {p[10:5], p[10:9]}, blue = {p[4:0], p[4:2]}.
- R8: data is 0 on every clock where de is 0.
- R9: vsync_edge is 1 for exactly one clock per frame, on the clock where vsync_n goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_rd | output | 1 | Frame-store read strobe, one per pixel |
| pix_addr | output | ADDR_W | Pixel index being read, raster order |
| pix_data | input | 16 | 5-6-5 pixel returned one clock after pix_rd |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high in the visible area |
| data | output | 8 | Colour byte bus |
| vsync_edge | output | 1 | One-clock pulse at the start of vertical sync |

## Verification
A wrong line or frame counter shows within one line as hsync_n or de edges in the wrong clocks. At a frame boundary it shows as a vsync_n edge out of place or a missing vsync_edge pulse. A byte-phase or pixel-latch fault swaps or repeats colour bytes on the next visible pixel. An address fault shows as a non-consecutive pix_addr on the second read of a line. The bench compares every output with an integer model on every clock, so each of these faults shows up on the first clock it affects.

// File: rtl/rgb_dotclk_gen.sv
module rgb_dotclk_gen #(
  parameter int H_PIX   = 320,
  parameter int V_LINES = 240,
  parameter int CPP     = 3,
  parameter int H_SYNC  = 8,
  parameter int H_BACK  = 24,
  parameter int H_FRONT = 4,
  parameter int V_SYNC  = 1,
  parameter int V_BACK  = 3,
  parameter int V_FRONT = 1,
  parameter int ADDR_W  = $clog2(H_PIX * V_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              pix_rd,
  output logic [ADDR_W-1:0] pix_addr,
  input  logic [15:0]       pix_data,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic [7:0]        data,
  output logic              vsync_edge
);
  localparam int HA0   = H_SYNC + H_BACK;
  localparam int HA1   = HA0 + H_PIX * CPP;
  localparam int H_TOT = HA1 + H_FRONT;
  localparam int VA0   = V_SYNC + V_BACK;
  localparam int VA1   = VA0 + V_LINES;
  localparam int V_TOT = VA1 + V_FRONT;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int PW    = (CPP > 1) ? $clog2(CPP) : 1;

  logic [HW-1:0]     hcnt;
  logic [VW-1:0]     vcnt;
  logic [PW-1:0]     ph;
  logic [ADDR_W-1:0] addr;
  logic              s1_hs, s1_vs, s1_de;
  logic [PW-1:0]     s1_ph;
  logic [15:0]       pix_q;
  logic [15:0]       src;
  logic [7:0]        byte_sel;

  wire h_end = (hcnt == HW'(H_TOT - 1));
  wire v_end = (vcnt == VW'(V_TOT - 1));
  wire act   = (hcnt >= HW'(HA0)) && (hcnt < HW'(HA1)) &&
               (vcnt >= VW'(VA0)) && (vcnt < VW'(VA1));

  assign pix_rd   = act && (ph == '0);
  assign pix_addr = addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      ph   <= '0;
      addr <= '0;
    end else begin
      hcnt <= h_end ? '0 : hcnt + HW'(1);
      if (h_end) vcnt <= v_end ? '0 : vcnt + VW'(1);
      if (act) ph <= (ph == PW'(CPP - 1)) ? '0 : ph + PW'(1);
      else     ph <= '0;
      if (h_end && v_end) addr <= '0;
      else if (pix_rd)    addr <= addr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_hs <= 1'b0;
      s1_vs <= 1'b0;
      s1_de <= 1'b0;
      s1_ph <= '0;
    end else begin
      s1_hs <= (hcnt < HW'(H_SYNC));
      s1_vs <= (vcnt < VW'(V_SYNC));
      s1_de <= act;
      s1_ph <= ph;
    end
  end

  assign src = (s1_ph == '0) ? pix_data : pix_q;

  always_comb begin
    if (int'(s1_ph) == 0)      byte_sel = {src[15:11], src[15:13]};
    else if (int'(s1_ph) == 1) byte_sel = {src[10:5], src[10:9]};
    else if (int'(s1_ph) == 2) byte_sel = {src[4:0], src[4:2]};
    else                       byte_sel = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_n    <= 1'b1;
      vsync_n    <= 1'b1;
      de         <= 1'b0;
      data       <= 8'h00;
      vsync_edge <= 1'b0;
      pix_q      <= '0;
    end else begin
      hsync_n    <= ~s1_hs;
      vsync_n    <= ~s1_vs;
      de         <= s1_de;
      data       <= s1_de ? byte_sel : 8'h00;
      vsync_edge <= s1_vs & vsync_n;
      if (s1_de && s1_ph == '0) pix_q <= pix_data;
    end
  end

  a_r8_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> data == 8'h00);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_edge |=> !vsync_edge);
  a_r9_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_edge |-> !vsync_n && $past(vsync_n));
  a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> hsync_n && vsync_n);
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rd |=> pix_addr == $past(pix_addr) + ADDR_W'(1));

  generate
    if (CPP > 1) begin : g_multi
      a_r5_one_read_per_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rd |=> !pix_rd);
    end
  endgenerate
endmodule

// File: tb/tb_rgb_dotclk_gen.sv
`timescale 1ns/1ps
module tb_rgb_dotclk_gen;
  localparam int HP = 4, VL = 3, CP = 3;
  localparam int HS = 2, HB = 3, HF = 2, VS = 1, VB = 2, VF = 1;
  localparam int AW = $clog2(HP * VL);
  localparam int HT = HS + HB + HP * CP + HF;
  localparam int VT = VS + VB + VL + VF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_rd, hsync_n, vsync_n, de, vsync_edge;
  logic [AW-1:0] pix_addr;
  logic [15:0] pix_data = 16'h0;
  logic [7:0] data;

  int tests = 0, fails = 0, k = 0;
  bit running = 0;

  always #5 clk = ~clk;

  rgb_dotclk_gen #(.H_PIX(HP), .V_LINES(VL), .CPP(CP), .H_SYNC(HS), .H_BACK(HB),
    .H_FRONT(HF), .V_SYNC(VS), .V_BACK(VB), .V_FRONT(VF), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .pix_rd(pix_rd), .pix_addr(pix_addr),
    .pix_data(pix_data), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .data(data), .vsync_edge(vsync_edge));

  function automatic logic [15:0] pattern(int a);
    case (a)
      0: return 16'hFFFF;
      1: return 16'hF800;
      2: return 16'h07E0;
      3: return 16'h001F;
      4: return 16'h0841;
      5: return 16'h0000;
      default: return 16'((a * 40503) ^ 23130);
    endcase
  endfunction

  function automatic int widen(logic [15:0] p, int phase);
    int r, g, b;
    r = (int'(p) >> 11) & 31;
    g = (int'(p) >> 5) & 63;
    b = int'(p) & 31;
    if (phase == 0) return r * 8 + r / 4;
    if (phase == 1) return g * 4 + g / 16;
    return b * 8 + b / 4;
  endfunction

  always @(posedge clk) if (pix_rd) pix_data <= pattern(int'(pix_addr));
  always @(posedge clk) if (rst_n) k <= k + 1;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, k, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      int c, h, v, x, y, ph, rh, rv;
      bit act_o, act_r;
      rh = k % HT; rv = (k / HT) % VT;
      act_r = rh >= HS + HB && rh < HS + HB + HP * CP && rv >= VS + VB && rv < VS + VB + VL;
      chk("R5 pix_rd", int'(pix_rd), int'(act_r && ((rh - HS - HB) % CP == 0)));
      if (pix_rd)
        chk("R5 pix_addr", int'(pix_addr), (rv - VS - VB) * HP + (rh - HS - HB) / CP);
      if (k < 2) begin
        chk("R1 hsync_n", int'(hsync_n), 1);
        chk("R1 vsync_n", int'(vsync_n), 1);
        chk("R1 de", int'(de), 0);
        chk("R1 data", int'(data), 0);
        chk("R1 vsync_edge", int'(vsync_edge), 0);
      end else begin
        c = k - 2; h = c % HT; v = (c / HT) % VT;
        act_o = h >= HS + HB && h < HS + HB + HP * CP && v >= VS + VB && v < VS + VB + VL;
        chk("R2 hsync_n", int'(hsync_n), int'(!(h < HS)));
        chk("R3 vsync_n", int'(vsync_n), int'(!(v < VS)));
        chk("R4 de", int'(de), int'(act_o));
        chk("R9 vsync_edge", int'(vsync_edge), int'(h == 0 && v == 0));
        if (act_o) begin
          ph = (h - HS - HB) % CP;
          x = (h - HS - HB) / CP;
          y = v - VS - VB;
          chk("R6 R7 data", int'(data), widen(pattern(y * HP + x), ph));
        end else begin
          chk("R8 data", int'(data), 0);
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 hsync_n in reset", int'(hsync_n), 1);
        chk("R1 vsync_n in reset", int'(vsync_n), 1);
        chk("R1 de in reset", int'(de), 0);
        chk("R1 data in reset", int'(data), 0);
        chk("R1 pix_rd in reset", int'(pix_rd), 0);
        rst_n = 1'b1;
        running = 1;
        repeat (3 * HT * VT + 5) @(posedge clk);
        @(negedge clk);
        running = 0;
      end
      begin
        while (wd < 20000) begin
          @(posedge clk);
          wd++;
        end
        fails++;
        tests++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule